// File: doc/BRIEF.md
# Selectable Clock Fanout with Glitch-Free Output Gating

This block picks one of two clock sources and fans the picked clock out to six outputs. One source is the fast system clock; the other is a slower scan or test clock. A single select input steers the choice. It is low by default, and when it is left undriven the board pulls it low so the system clock is chosen. Each output is a true and complement pair.

Every output can be stopped on its own or together with all others through one shared disable. The disable inputs are sampled by falling-edge flip-flops clocked by the picked clock. An output can therefore stop or start only while the clock is already low. A high pulse is never cut short, and no partial pulse appears when an output restarts.

Top module: `clk_fanout_gate`

## Requirements
- R1: With sel_i at 1'b0 the system clock drives every enabled true output.
- R2: With sel_i at 1'b1 the test clock drives every enabled true output.
- R3: An undriven select is pulled to 1'b0 outside the block, so the system clock is used.
- R4: While rst_ni is low, all enable flip-flops are cleared at once, every clk_o bit is 0 and every clk_no bit is 1.
- R5: Setting dis_all_i forces every true output low from the next falling edge of the picked clock.
- R6: Setting dis_i[k] forces only output k low from the next falling edge; the other outputs keep running.
- R7: A disable that arrives during a high phase lets that high phase finish in full; enables change only at falling edges of the picked clock.
- R8: Every high pulse on a true output lasts exactly one full high phase of the picked clock, including the first pulse after a restart.
- R9: clk_no[k] is always the inverse of clk_o[k].
- R10: Output k runs only if both dis_all_i and dis_i[k] were low at the last falling edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sys_clk_i | input | 1 | Fast system clock source |
| tst_clk_i | input | 1 | Slow scan/test clock source |
| sel_i | input | 1 | Source select, 0 picks system clock, 1 picks test clock |
| rst_ni | input | 1 | Asynchronous active-low reset of the enable flip-flops |
| dis_all_i | input | 1 | Shared disable for all outputs |
| dis_i | input | 6 | Disable for each output, bit k controls output k |
| clk_o | output | 6 | Gated clock outputs, true phase |
| clk_no | output | 6 | Gated clock outputs, complement phase |

## Verification
The assertions check on every cycle that the complement tracks the true output. They also check that outputs stay low during reset and that enables never move while the picked clock is high. Finally, they check that each disable term takes effect at the following falling edge and that enabled outputs carry whichever source is selected. The bench scenarios are needed to show the full pulse width on each output, the pulldown default of the select, clean switching between the two sources while both are low, and the exact cycle at which a disable arriving mid-pulse takes effect.

// File: rtl/clk_fanout_pkg.sv
`timescale 1ns/1ps
package clk_fanout_pkg;
  localparam int unsigned DEF_OUTS = 6;

  function automatic logic gate_enable(input logic dis_all, input logic dis_one);
    return !(dis_all || dis_one);
  endfunction
endpackage

// File: rtl/clk_src_mux.sv
`timescale 1ns/1ps
module clk_src_mux (
  input  logic sys_clk_i,
  input  logic tst_clk_i,
  input  logic sel_i,
  output logic clk_o
);
  assign clk_o = sel_i ? tst_clk_i : sys_clk_i;
endmodule

// File: rtl/clk_en_reg.sv
`timescale 1ns/1ps
module clk_en_reg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic dis_all_i,
  input  logic dis_one_i,
  output logic en_o
);
  import clk_fanout_pkg::*;

  // falling edge: enable changes only while the clock is low
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_o <= 1'b0;
    else         en_o <= gate_enable(dis_all_i, dis_one_i);
  end
endmodule

// File: rtl/clk_gate_cell.sv
`timescale 1ns/1ps
module clk_gate_cell (
  input  logic clk_i,
  input  logic en_i,
  output logic clk_o,
  output logic clk_no
);
  logic gated;
  assign gated  = clk_i & en_i;
  assign clk_o  = gated;
  assign clk_no = ~gated;
endmodule

// File: rtl/clk_fanout_gate.sv
`timescale 1ns/1ps
module clk_fanout_gate #(
  parameter int unsigned N_OUT = clk_fanout_pkg::DEF_OUTS
) (
  input  logic             sys_clk_i,
  input  logic             tst_clk_i,
  input  logic             sel_i,
  input  logic             rst_ni,
  input  logic             dis_all_i,
  input  logic [N_OUT-1:0] dis_i,
  output logic [N_OUT-1:0] clk_o,
  output logic [N_OUT-1:0] clk_no
);
  logic             clk_sel;
  logic [N_OUT-1:0] en_q;

  clk_src_mux u_mux (
    .sys_clk_i (sys_clk_i),
    .tst_clk_i (tst_clk_i),
    .sel_i     (sel_i),
    .clk_o     (clk_sel)
  );

  for (genvar k = 0; k < N_OUT; k++) begin : g_out
    clk_en_reg u_en (
      .clk_i     (clk_sel),
      .rst_ni    (rst_ni),
      .dis_all_i (dis_all_i),
      .dis_one_i (dis_i[k]),
      .en_o      (en_q[k])
    );

    clk_gate_cell u_gate (
      .clk_i  (clk_sel),
      .en_i   (en_q[k]),
      .clk_o  (clk_o[k]),
      .clk_no (clk_no[k])
    );
  end
endmodule

// File: rtl/clk_fanout_gate_chk.sv
`timescale 1ns/1ps
module clk_fanout_gate_chk #(
  parameter int unsigned N_OUT = 6
) (
  input logic             sys_clk_i,
  input logic             tst_clk_i,
  input logic             sel_i,
  input logic             rst_ni,
  input logic             dis_all_i,
  input logic [N_OUT-1:0] dis_i,
  input logic [N_OUT-1:0] clk_o,
  input logic [N_OUT-1:0] clk_no,
  input logic             clk_sel_i,
  input logic [N_OUT-1:0] en_q_i
);
  a_r9_complement: assert property (@(posedge sys_clk_i) disable iff (!rst_ni)
    clk_no == ~clk_o);

  a_r4_reset_clears: assert property (@(posedge sys_clk_i)
    !rst_ni |-> (clk_o == '0));

  a_r7_hold_in_high: assert property (@(posedge sys_clk_i) disable iff (!rst_ni)
    (clk_sel_i && $past(clk_sel_i)) |-> $stable(en_q_i));

  a_r5_common_off: assert property (@(negedge clk_sel_i) disable iff (!rst_ni)
    dis_all_i |=> (en_q_i == '0));

  a_r1_sys_route: assert property (@(negedge sys_clk_i) disable iff (!rst_ni)
    !sel_i |-> ((clk_o & en_q_i) == en_q_i));

  a_r2_tst_route: assert property (@(negedge tst_clk_i) disable iff (!rst_ni)
    sel_i |-> ((clk_o & en_q_i) == en_q_i));

  for (genvar k = 0; k < N_OUT; k++) begin : g_chk
    a_r6_own_off: assert property (@(negedge clk_sel_i) disable iff (!rst_ni)
      dis_i[k] |=> !en_q_i[k]);

    a_r10_both_clear: assert property (@(negedge clk_sel_i) disable iff (!rst_ni)
      (!dis_all_i && !dis_i[k]) |=> en_q_i[k]);
  end
endmodule

bind clk_fanout_gate clk_fanout_gate_chk #(.N_OUT(N_OUT)) u_chk (
  .sys_clk_i (sys_clk_i),
  .tst_clk_i (tst_clk_i),
  .sel_i     (sel_i),
  .rst_ni    (rst_ni),
  .dis_all_i (dis_all_i),
  .dis_i     (dis_i),
  .clk_o     (clk_o),
  .clk_no    (clk_no),
  .clk_sel_i (clk_sel),
  .en_q_i    (en_q)
);

// File: tb/clk_fanout_gate_bench.sv
`timescale 1ns/1ps
module clk_fanout_gate_bench;
  localparam int N = 6;
  localparam int SYS_HALF = 10;  // 50 MHz
  localparam int TST_HALF = 40;

  logic sys_clk = 1'b0;
  logic tst_clk = 1'b0;
  logic rst_n, dis_all, sel_oe, sel_val;
  logic [N-1:0] dis;
  logic sel_w;
  logic [N-1:0] clk_o, clk_no;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string phase = "R4 reset";

  // board pulldown on the select line (R3)
  assign sel_w = sel_oe ? sel_val : 1'b0;

  always #SYS_HALF sys_clk = ~sys_clk;
  always #TST_HALF tst_clk = ~tst_clk;

  clk_fanout_gate u_clk_fanout_gate (
    .sys_clk_i (sys_clk),
    .tst_clk_i (tst_clk),
    .sel_i     (sel_w),
    .rst_ni    (rst_n),
    .dis_all_i (dis_all),
    .dis_i     (dis),
    .clk_o     (clk_o),
    .clk_no    (clk_no)
  );

  // behavioural reference
  logic ref_clk;
  bit   ref_on [N];
  assign ref_clk = sel_w ? tst_clk : sys_clk;

  always @(negedge ref_clk or negedge rst_n) begin
    for (int i = 0; i < N; i++)
      ref_on[i] = rst_n && !dis_all && !dis[i];
  end

  function automatic logic [N-1:0] expect_out();
    logic [N-1:0] v;
    for (int i = 0; i < N; i++) v[i] = ref_clk & ref_on[i];
    return v;
  endfunction

  task automatic check_vec(string tag, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s t=%0t actual=%b expected=%b", tag, $time, act, exp);
    end
  endtask

  // compare on every system clock edge, away from the edge
  always begin
    @(sys_clk);
    #2;
    if (!done) begin
      check_vec(phase, clk_o, expect_out());
      check_vec("R9 complement", clk_no, ~expect_out());
    end
  end

  // pulse integrity per output (R8)
  for (genvar g = 0; g < N; g++) begin : g_pw
    longint t_rise = -1;
    always @(posedge clk_o[g]) t_rise = $time;
    always @(negedge clk_o[g]) begin
      if (rst_n && t_rise >= 0 && !done) begin
        longint w, e;
        w = $time - t_rise;
        e = sel_w ? TST_HALF : SYS_HALF;
        checks++;
        if (w != e) begin
          errors++;
          $display("FAIL R8 out%0d pulse width actual=%0d expected=%0d", g, w, e);
        end
      end
    end
  end

  task automatic wait_to(int m, int off);
    while (($time % m) != off) #1;
  endtask

  task automatic cycles(int n);
    repeat (n) @(posedge sys_clk);
  endtask

  initial begin
    rst_n = 1'b1; dis_all = 1'b0; dis = '0; sel_oe = 1'b0; sel_val = 1'b0;
    #1 rst_n = 1'b0;
    #60;
    check_vec("R4 reset true low", clk_o, '0);
    check_vec("R4 reset complement high", clk_no, '1);
    wait_to(20, 3);
    rst_n = 1'b1;
    phase = "R1 R3 undriven select uses system clock";
    cycles(8);

    phase = "R6 R7 single disable mid-high";
    wait_to(20, 15);
    dis = 6'b000100;
    #1 check_vec("R7 pulse kept after mid-high disable", clk_o, 6'b111111);
    cycles(4);
    wait_to(20, 15);
    dis = '0;
    #1 check_vec("R8 no partial pulse on restart", clk_o, 6'b111011);
    cycles(4);

    phase = "R5 common disable";
    wait_to(20, 15);
    dis_all = 1'b1;
    cycles(3);
    wait_to(20, 15);
    check_vec("R5 all outputs held low", clk_o, '0);

    phase = "R10 both disables";
    dis = 6'b101001;
    cycles(2);
    wait_to(20, 15);
    dis_all = 1'b0;
    cycles(3);
    wait_to(20, 15);
    check_vec("R10 only fully enabled outputs run", clk_o, 6'b010110);
    dis = '0;
    cycles(2);

    phase = "R6 walking disable";
    for (int k = 0; k < N; k++) begin
      wait_to(20, 5);
      dis = 6'(1) << k;
      cycles(2);
    end
    wait_to(20, 5);
    dis = '0;
    cycles(3);

    phase = "R2 test clock selected";
    wait_to(80, 3);
    sel_oe = 1'b1; sel_val = 1'b1;
    cycles(12);
    phase = "R2 R7 disables on test clock";
    wait_to(80, 55);
    dis = 6'b010010;
    cycles(12);
    wait_to(80, 55);
    dis_all = 1'b1;
    cycles(8);
    wait_to(80, 55);
    dis_all = 1'b0; dis = '0;
    cycles(12);

    phase = "R1 back to system clock";
    wait_to(80, 3);
    sel_val = 1'b0;
    cycles(8);
    wait_to(80, 3);
    sel_oe = 1'b0;
    phase = "R3 select released";
    cycles(8);

    phase = "R4 asynchronous reset";
    wait_to(20, 5);
    rst_n = 1'b0;
    #1 check_vec("R4 async reset true low", clk_o, '0);
    check_vec("R4 async reset complement high", clk_no, '1);
    cycles(4);
    wait_to(20, 3);
    rst_n = 1'b1;
    phase = "R1 after reset";
    cycles(8);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule